// File: doc/BRIEF.md
# Mode-Controlled Word Serializer

This block turns a parallel data word into a serial bit stream. It holds the word in an internal register. On every rising clock edge a two-bit operation code chooses what the register does: it keeps its contents, captures the parallel input, or moves one place toward the most significant end with a zero entering at the bottom. Two of the four code values both mean "keep".

The serial output is a flip-flop of its own, separate from the internal register. After every capture or move it shows the bit that then sits at the most significant end. To send a word, capture it once and then apply one move per bit. The output presents the bits from the most significant down to the least, and a zero once the word has been fully sent.

An active-high reset clears the register and the serial output at once, without waiting for a clock edge. Framing, bit counting and handshaking are left to the logic around the block.

Top module: `word_serializer`

## Requirements
- R1: Operation code 2'b00 leaves the internal register and the serial output unchanged at the clock edge, whatever the parallel input holds.
- R2: Operation code 2'b01 copies the parallel input into the internal register at the rising edge, and the serial output then shows bit WIDTH-1 of that input.
- R3: Operation code 2'b10 moves the internal register one position toward the most significant end at the rising edge, with 0 entering bit 0. The serial output then shows the new bit WIDTH-1.
- R4: Operation code 2'b11 behaves exactly like 2'b00: register and serial output are kept.
- R5: While the active-high reset is asserted, the register and the serial output are 0. Reset takes effect at once and does not wait for a clock edge.
- R6: The serial output is registered. It equals the most significant register bit, and a change of operation code or parallel input shows on it only after the next rising edge.
- R7: A capture followed by WIDTH moves presents every bit of the captured word on the serial output, most significant first. After that the register is all zero, so further moves keep the output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high asynchronous reset |
| parIn | input | WIDTH | Parallel word to capture |
| mode | input | 2 | Operation code: 00 keep, 01 capture, 10 move left, 11 keep |
| serOut | output | 1 | Registered serial bit, most significant end of the register |

## Verification
The bench builds the block with the default WIDTH of 8. At that size a random stream of operation codes and words covers all 256 input words and every operation code in many orderings. A full capture-and-drain run of eight moves, plus the zero tail after it, also fits in a few directed steps. At this width a kept register can be told apart from a wrongly reloaded or moved one: a later move exposes the next bit, and that bit differs between the two cases.

// File: rtl/word_serializer_pkg.sv
`timescale 1ns/1ps
package word_serializer_pkg;

  // Operation codes seen on the mode input
  typedef enum logic [1:0] {
    OP_KEEP_LO = 2'b00,
    OP_CAPTURE = 2'b01,
    OP_MOVE    = 2'b10,
    OP_KEEP_HI = 2'b11
  } opCode_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic captureStb;
    logic moveStb;
  } stepCtl_t;

endpackage

// File: rtl/word_serializer_ctrl.sv
`timescale 1ns/1ps
module word_serializer_ctrl
  import word_serializer_pkg::*;
(
  input  logic [1:0] mode,
  output stepCtl_t   stepCtl
);

  opCode_e opCode;

  assign opCode = opCode_e'(mode);

  always_comb begin
    stepCtl = '0;
    unique case (opCode)
      OP_CAPTURE: stepCtl.captureStb = 1'b1;
      OP_MOVE:    stepCtl.moveStb    = 1'b1;
      OP_KEEP_LO,
      OP_KEEP_HI: stepCtl = '0;
      default:    stepCtl = '0;
    endcase
  end

endmodule

// File: rtl/word_serializer_path.sv
`timescale 1ns/1ps
module word_serializer_path
  import word_serializer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stepCtl_t         stepCtl,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] regImage,
  output logic             serOut
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] movedWord;

  // Shifted image: each bit takes its lower neighbour, bit 0 takes zero
  for (genvar i = 0; i < WIDTH; i++) begin : g_move
    if (i == 0) begin : g_fill
      assign movedWord[i] = 1'b0;
    end else begin : g_link
      assign movedWord[i] = regImage[i-1];
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      regImage <= '0;
      serOut   <= 1'b0;
    end else if (stepCtl.captureStb) begin
      regImage <= parIn;
      serOut   <= parIn[TOP];
    end else if (stepCtl.moveStb) begin
      regImage <= movedWord;
      serOut   <= movedWord[TOP];
    end
  end

endmodule

// File: rtl/word_serializer.sv
`timescale 1ns/1ps
module word_serializer
  import word_serializer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] parIn,
  input  logic [1:0]       mode,
  output logic             serOut
);

  stepCtl_t         stepCtl;
  logic [WIDTH-1:0] regImage;

  word_serializer_ctrl ctrl_i (
    .mode    (mode),
    .stepCtl (stepCtl)
  );

  word_serializer_path #(.WIDTH(WIDTH)) path_i (
    .clk      (clk),
    .rst      (rst),
    .stepCtl  (stepCtl),
    .parIn    (parIn),
    .regImage (regImage),
    .serOut   (serOut)
  );

endmodule

// File: rtl/word_serializer_chk.sv
`timescale 1ns/1ps
module word_serializer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] parIn,
  input logic [1:0]       mode,
  input logic             serOut,
  input logic [WIDTH-1:0] regImage
);

  assert_keep_lo_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> ($stable(regImage) && $stable(serOut)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (regImage == $past(parIn)));

  assert_move_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (regImage == {$past(regImage[WIDTH-2:0]), 1'b0}));

  assert_keep_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> ($stable(regImage) && $stable(serOut)));

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |-> (regImage == '0 && serOut == 1'b0));

  assert_msb_track_R6: assert property (@(posedge clk) disable iff (rst)
    serOut == regImage[WIDTH-1]);

endmodule

bind word_serializer word_serializer_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .parIn    (parIn),
  .mode     (mode),
  .serOut   (serOut),
  .regImage (regImage)
);

// File: tb/word_serializer_tb_top.sv
`timescale 1ns/1ps
module word_serializer_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic [W-1:0] parIn = '0;
  logic [1:0]   mode = 2'b00;
  logic         serOut;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  word_serializer #(.WIDTH(W)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .parIn  (parIn),
    .mode   (mode),
    .serOut (serOut)
  );

  function automatic logic [W-1:0] next_model(logic [W-1:0] cur, logic [1:0] m, logic [W-1:0] d);
    case (m)
      2'b01:   return d;
      2'b10:   return {cur[W-2:0], 1'b0};
      default: return cur;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s serOut actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(logic [1:0] m, logic [W-1:0] d, string tag);
    @(negedge clk);
    mode  = m;
    parIn = d;
    @(posedge clk);
    #2;
    model = next_model(model, m, d);
    check_bit(tag, serOut, model[W-1]);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog serOut actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] pattern;
    void'($urandom(32'd20240611));

    // R5: reset clears output
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 check_bit("R5", serOut, 1'b0);
    @(negedge clk) rst = 1'b0;
    model = '0;

    // R2 then R7: capture and drain MSB first, then zeros
    pattern = 8'hA5;
    step(2'b01, pattern, "R2");
    for (int k = 0; k < W; k++) step(2'b10, 8'h00, "R7");
    step(2'b10, 8'hFF, "R7");
    step(2'b10, 8'h3C, "R3");

    // R1: keep with code 00 while input toggles, then move exposes kept bit
    step(2'b01, 8'h40, "R2");
    step(2'b00, 8'hFF, "R1");
    step(2'b00, 8'h80, "R1");
    step(2'b10, 8'h00, "R1");

    // R4: code 11 behaves as keep
    step(2'b01, 8'h20, "R2");
    step(2'b11, 8'hFF, "R4");
    step(2'b10, 8'h80, "R4");
    step(2'b10, 8'h00, "R4");

    // R6: new code has no effect before the edge
    step(2'b01, 8'h00, "R2");
    @(negedge clk);
    mode  = 2'b01;
    parIn = 8'hFF;
    #2 check_bit("R6", serOut, 1'b0);
    @(posedge clk);
    #2;
    model = 8'hFF;
    check_bit("R6", serOut, 1'b1);

    // R5: asynchronous clear between edges
    @(negedge clk);
    mode = 2'b00;
    #1 rst = 1'b1;
    #1 check_bit("R5", serOut, 1'b0);
    @(posedge clk);
    #2 check_bit("R5", serOut, 1'b0);
    @(negedge clk) rst = 1'b0;
    model = '0;
    step(2'b00, 8'hFF, "R5");
    step(2'b10, 8'hFF, "R5");

    // Random mix across all codes
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]   m;
      logic [W-1:0] d;
      m = 2'($urandom_range(3, 0));
      d = W'($urandom);
      step(m, d, tag_of(m));
    end

    finished = 1'b1;
    summary();
  end

endmodule